// File: doc/BRIEF.md
# Accumulator Test-Skip and Status Operate Unit

This block executes the operate-class instructions that test and modify the two main accumulators (J and K) of a 12-bit processor, together with its overflow bit and a general-purpose flag bit. The sequencer presents one instruction word with a valid strobe, along with the current accumulator and status values. One clock later the unit returns the updated values and a skip request for the program counter logic.

A single word can name J, K or both. When both are named, a test is applied jointly and a modify operation is applied to each accumulator. When neither is named, the same low code field instead tests or changes the overflow and flag bits, or requests an unconditional skip. Words that do not belong to this instruction class pass the register values through unchanged and never request a skip. This lets the unit sit in the datapath permanently.

Top module: `g2_operate_unit`

## Requirements
- R1: A valid word whose bits 11..8 are not 0011 returns J, K, overflow and flag unchanged, with no skip.
- R2: Bit 6 selects J and bit 7 selects K. A modify operation leaves an accumulator that is not selected unchanged.
- R3: With one accumulator selected, low code 05 skips if it is zero, 01 if it is nonzero, 02 if its bit 11 is 0 (so zero counts as positive), and 06 if its bit 11 is 1.
- R4: With both selected, code 05 skips only if both are zero, and 01 skips if either is nonzero. Code 02 skips only if both are positive, and 06 only if both are negative.
- R5: On each selected accumulator, code 10 clears it, 20 complements it and 30 sets it to all ones.
- R6: Code 04 increments and code 24 negates (two's complement) each selected accumulator, wrapping modulo 4096. No accumulator-form word changes overflow or flag.
- R7: With neither accumulator selected, code 45 skips if overflow is 0 and 41 skips if it is 1. Codes 50, 60 and 70 clear, complement and set overflow, and leave the flag unchanged.
- R8: With neither accumulator selected, code 05 skips if the flag is 0 and 01 skips if it is 1. Codes 10, 20 and 30 clear, complement and set the flag, and leave overflow unchanged.
- R9: Word octal 1442 always skips. Word octal 1400 changes nothing and does not skip.
- R10: Results and done_o appear on the cycle after valid_i is sampled high. skip_o is high only in such a cycle, and for exactly one cycle per word.
- R11: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word valid |
| instr_i | input | 12 | Instruction word |
| j_i | input | DW | Current J |
| k_i | input | DW | Current K |
| ovf_i | input | 1 | Current overflow bit |
| flag_i | input | 1 | Current flag bit |
| j_o | output | DW | Updated J |
| k_o | output | DW | Updated K |
| ovf_o | output | 1 | Updated overflow bit |
| flag_o | output | 1 | Updated flag bit |
| skip_o | output | 1 | Skip request, one-cycle pulse |
| done_o | output | 1 | Results valid this cycle |

## Verification
The hardest cases are the joint conditions. Each needs the two accumulators to disagree in a specific way: one zero and one nonzero for the zero and nonzero tests, and opposite signs for the sign tests. The stimulus therefore drives pairs with exactly one accumulator failing the test, and then pairs where both pass. Wrap-around at the increment and negate boundaries (all ones, and zero) is driven directly through the J and K inputs, with overflow preset to the value that a faulty carry would disturb.

// File: rtl/g2_pkg.sv
package g2_pkg;
  localparam int unsigned IW = 12;
  localparam logic [3:0] GRP_TAG = 4'b0011;

  // accumulator-form codes
  localparam logic [5:0] LC_SKZ  = 6'o05;
  localparam logic [5:0] LC_SKNZ = 6'o01;
  localparam logic [5:0] LC_SKP  = 6'o02;
  localparam logic [5:0] LC_SKN  = 6'o06;
  localparam logic [5:0] LC_CLR  = 6'o10;
  localparam logic [5:0] LC_CMP  = 6'o20;
  localparam logic [5:0] LC_SET  = 6'o30;
  localparam logic [5:0] LC_INC  = 6'o04;
  localparam logic [5:0] LC_NEG  = 6'o24;

  // status-form codes
  localparam logic [5:0] SC_FZ   = 6'o05;
  localparam logic [5:0] SC_FNZ  = 6'o01;
  localparam logic [5:0] SC_OZ   = 6'o45;
  localparam logic [5:0] SC_ONZ  = 6'o41;
  localparam logic [5:0] SC_ALW  = 6'o42;
  localparam logic [5:0] SC_FCLR = 6'o10;
  localparam logic [5:0] SC_FCMP = 6'o20;
  localparam logic [5:0] SC_FSET = 6'o30;
  localparam logic [5:0] SC_OCLR = 6'o50;
  localparam logic [5:0] SC_OCMP = 6'o60;
  localparam logic [5:0] SC_OSET = 6'o70;

  typedef enum logic [2:0] {
    TEST_NONE, TEST_ZERO, TEST_NZ, TEST_POS, TEST_NEG
  } test_e;

  function automatic test_e lane_test(input logic [5:0] code);
    case (code)
      LC_SKZ:  return TEST_ZERO;
      LC_SKNZ: return TEST_NZ;
      LC_SKP:  return TEST_POS;
      LC_SKN:  return TEST_NEG;
      default: return TEST_NONE;
    endcase
  endfunction
endpackage

// File: rtl/g2_acc_lane.sv
module g2_acc_lane
  import g2_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic          sel_i,
  input  logic [5:0]    code_i,
  input  logic [DW-1:0] val_i,
  output logic [DW-1:0] val_o,
  output logic          zero_o,
  output logic          neg_o
);
  logic [DW-1:0] mod_val;

  always_comb begin
    case (code_i)
      LC_CLR:  mod_val = '0;
      LC_CMP:  mod_val = ~val_i;
      LC_SET:  mod_val = '1;
      LC_INC:  mod_val = val_i + DW'(1);
      LC_NEG:  mod_val = ~val_i + DW'(1);
      default: mod_val = val_i;
    endcase
  end

  assign val_o  = sel_i ? mod_val : val_i;
  assign zero_o = (val_i == '0);
  assign neg_o  = val_i[DW-1];
endmodule

// File: rtl/g2_skip_join.sv
module g2_skip_join
  import g2_pkg::*;
#(
  parameter int unsigned NL = 2
) (
  input  logic [NL-1:0] sel_i,
  input  logic [NL-1:0] zero_i,
  input  logic [NL-1:0] neg_i,
  input  test_e         test_i,
  output logic          skip_o
);
  logic all_zero, any_nz, all_pos, all_neg;

  // unselected lanes are neutral in each reduction
  assign all_zero = &(zero_i | ~sel_i);
  assign any_nz   = |(~zero_i & sel_i);
  assign all_pos  = &(~neg_i | ~sel_i);
  assign all_neg  = &(neg_i | ~sel_i);

  always_comb begin
    case (test_i)
      TEST_ZERO: skip_o = all_zero;
      TEST_NZ:   skip_o = any_nz;
      TEST_POS:  skip_o = all_pos;
      TEST_NEG:  skip_o = all_neg;
      default:   skip_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/g2_status_ops.sv
module g2_status_ops
  import g2_pkg::*;
(
  input  logic       active_i,
  input  logic [5:0] code_i,
  input  logic       ovf_i,
  input  logic       flag_i,
  output logic       ovf_o,
  output logic       flag_o,
  output logic       skip_o
);
  always_comb begin
    ovf_o  = ovf_i;
    flag_o = flag_i;
    skip_o = 1'b0;
    if (active_i) begin
      case (code_i)
        SC_FZ:   skip_o = ~flag_i;
        SC_FNZ:  skip_o = flag_i;
        SC_OZ:   skip_o = ~ovf_i;
        SC_ONZ:  skip_o = ovf_i;
        SC_ALW:  skip_o = 1'b1;
        SC_FCLR: flag_o = 1'b0;
        SC_FCMP: flag_o = ~flag_i;
        SC_FSET: flag_o = 1'b1;
        SC_OCLR: ovf_o  = 1'b0;
        SC_OCMP: ovf_o  = ~ovf_i;
        SC_OSET: ovf_o  = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/g2_operate_unit.sv
module g2_operate_unit
  import g2_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [11:0]   instr_i,
  input  logic [DW-1:0] j_i,
  input  logic [DW-1:0] k_i,
  input  logic          ovf_i,
  input  logic          flag_i,
  output logic [DW-1:0] j_o,
  output logic [DW-1:0] k_o,
  output logic          ovf_o,
  output logic          flag_o,
  output logic          skip_o,
  output logic          done_o
);
  localparam int unsigned NL = 2;  // lane 0 = J (bit 6), lane 1 = K (bit 7)

  logic          is_grp;
  logic [NL-1:0] sel;
  logic [5:0]    code;
  logic [DW-1:0] lane_in  [NL];
  logic [DW-1:0] lane_out [NL];
  logic [NL-1:0] lane_zero, lane_neg;
  logic          acc_skip, st_skip, st_ovf, st_flag, nxt_skip;

  assign is_grp     = (instr_i[11:8] == GRP_TAG);
  assign sel        = is_grp ? instr_i[7:6] : '0;
  assign code       = instr_i[5:0];
  assign lane_in[0] = j_i;
  assign lane_in[1] = k_i;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    g2_acc_lane #(.DW(DW)) u_lane (
      .sel_i  (sel[g]),
      .code_i (code),
      .val_i  (lane_in[g]),
      .val_o  (lane_out[g]),
      .zero_o (lane_zero[g]),
      .neg_o  (lane_neg[g])
    );
  end

  g2_skip_join #(.NL(NL)) u_join (
    .sel_i  (sel),
    .zero_i (lane_zero),
    .neg_i  (lane_neg),
    .test_i (lane_test(code)),
    .skip_o (acc_skip)
  );

  g2_status_ops u_status (
    .active_i (is_grp && (sel == '0)),
    .code_i   (code),
    .ovf_i    (ovf_i),
    .flag_i   (flag_i),
    .ovf_o    (st_ovf),
    .flag_o   (st_flag),
    .skip_o   (st_skip)
  );

  assign nxt_skip = (sel != '0) ? acc_skip : st_skip;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      j_o    <= '0;
      k_o    <= '0;
      ovf_o  <= 1'b0;
      flag_o <= 1'b0;
      skip_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= valid_i;
      skip_o <= valid_i & nxt_skip;
      if (valid_i) begin
        j_o    <= lane_out[0];
        k_o    <= lane_out[1];
        ovf_o  <= st_ovf;
        flag_o <= st_flag;
      end
    end
  end

  a_r1_foreign_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (instr_i[11:8] != 4'b0011) |=>
      !skip_o && j_o == $past(j_i) && k_o == $past(k_i) && ovf_o == $past(ovf_i));

  a_r2_k_unselected_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (instr_i[11:8] == 4'b0011) && !instr_i[7] |=> k_o == $past(k_i));

  a_r4_joint_zero_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && instr_i == 12'o1705 && (j_i != '0 || k_i != '0) |=> !skip_o);

  a_r6_acc_keeps_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (instr_i[11:8] == 4'b0011) && (instr_i[7:6] != 2'b00) |=>
      ovf_o == $past(ovf_i) && flag_o == $past(flag_i));

  a_r9_always_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && instr_i == 12'o1442 |=> skip_o);

  a_r10_done_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o && !skip_o);
endmodule

// File: tb/g2_operate_unit_bench.sv
module g2_operate_unit_bench;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [11:0]   instr = '0;
  logic [DW-1:0] j_in = '0, k_in = '0;
  logic          ov_in = 1'b0, f_in = 1'b0;
  logic [DW-1:0] j_out, k_out;
  logic          ov_out, f_out, skip, done;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  g2_operate_unit #(.DW(DW)) u_g2_operate_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr),
    .j_i(j_in), .k_i(k_in), .ovf_i(ov_in), .flag_i(f_in),
    .j_o(j_out), .k_o(k_out), .ovf_o(ov_out), .flag_o(f_out),
    .skip_o(skip), .done_o(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0o expected=%0o", tag, act, exp);
    end
  endtask

  // drive one word for one cycle; outputs are sampled on the next falling edge
  task automatic issue(input logic [11:0] w, input logic [DW-1:0] j, input logic [DW-1:0] k,
                       input logic ov, input logic f);
    @(negedge clk);
    valid = 1'b1; instr = w; j_in = j; k_in = k; ov_in = ov; f_in = f;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic t_reset();
    chk("R11 j", j_out, 0);
    chk("R11 k", k_out, 0);
    chk("R11 skip/done", {skip, done, ov_out, f_out}, 0);
  endtask

  task automatic t_foreign();
    issue(12'o5000, 12'o0123, 12'o4567, 1'b1, 1'b1);
    chk("R1 j", j_out, 12'o0123);
    chk("R1 k", k_out, 12'o4567);
    chk("R1 status,skip", {ov_out, f_out, skip}, 3'b110);
  endtask

  task automatic t_single();
    issue(12'o1505, 0, 12'o7, 0, 0);        chk("R3 J zero skip", skip, 1);
    issue(12'o1505, 1, 0, 0, 0);            chk("R3 J zero noskip", skip, 0);
    issue(12'o1501, 12'o5, 0, 0, 0);        chk("R3 J nonzero", skip, 1);
    issue(12'o1602, 12'o4000, 0, 0, 0);     chk("R3 K zero is positive", skip, 1);
    issue(12'o1602, 0, 12'o4000, 0, 0);     chk("R3 K negative not pos", skip, 0);
    issue(12'o1506, 12'o7777, 0, 0, 0);     chk("R3 J negative", skip, 1);
    issue(12'o1606, 12'o7777, 12'o3777, 0, 0); chk("R3 K not negative", skip, 0);
  endtask

  task automatic t_joint();
    issue(12'o1705, 0, 1, 0, 0);            chk("R4 zero one fails", skip, 0);
    issue(12'o1705, 0, 0, 0, 0);            chk("R4 zero both", skip, 1);
    issue(12'o1701, 0, 3, 0, 0);            chk("R4 nonzero either", skip, 1);
    issue(12'o1701, 0, 0, 0, 0);            chk("R4 nonzero none", skip, 0);
    issue(12'o1702, 1, 12'o4000, 0, 0);     chk("R4 pos mixed", skip, 0);
    issue(12'o1702, 0, 12'o3777, 0, 0);     chk("R4 pos both", skip, 1);
    issue(12'o1706, 12'o4000, 12'o1, 0, 0); chk("R4 neg mixed", skip, 0);
    issue(12'o1706, 12'o4000, 12'o7777, 0, 0); chk("R4 neg both", skip, 1);
  endtask

  task automatic t_modify();
    issue(12'o1510, 12'o1234, 12'o77, 0, 0);
    chk("R5 clear J", j_out, 0);
    chk("R2 K untouched", k_out, 12'o77);
    issue(12'o1620, 12'o1111, 12'o0707, 0, 0);
    chk("R5 complement K", k_out, 12'o7070);
    chk("R2 J untouched", j_out, 12'o1111);
    issue(12'o1730, 12'o1, 12'o2, 0, 0);
    chk("R5 set both", {j_out, k_out}, {12'o7777, 12'o7777});
  endtask

  task automatic t_incneg();
    issue(12'o1504, 12'o7777, 12'o5, 0, 0);
    chk("R6 inc wrap", j_out, 0);
    chk("R6 ov kept 0", {ov_out, f_out}, 2'b00);
    issue(12'o1724, 12'o1, 12'o0, 1, 1);
    chk("R6 neg J", j_out, 12'o7777);
    chk("R6 neg zero K", k_out, 0);
    chk("R6 ov,flag kept 1", {ov_out, f_out}, 2'b11);
    issue(12'o1604, 12'o3, 12'o3777, 0, 1);
    chk("R6 inc K", k_out, 12'o4000);
  endtask

  task automatic t_ovf();
    issue(12'o1445, 0, 0, 0, 1); chk("R7 skip ov clear", skip, 1);
    issue(12'o1445, 0, 0, 1, 0); chk("R7 noskip ov set", skip, 0);
    issue(12'o1441, 0, 0, 1, 0); chk("R7 skip ov set", skip, 1);
    issue(12'o1450, 0, 0, 1, 1); chk("R7 clear ov", {ov_out, f_out}, 2'b01);
    issue(12'o1460, 0, 0, 0, 0); chk("R7 comp ov", {ov_out, f_out}, 2'b10);
    issue(12'o1470, 12'o17, 12'o21, 0, 1);
    chk("R7 set ov", {ov_out, f_out}, 2'b11);
    chk("R7 acc untouched", {j_out, k_out}, {12'o17, 12'o21});
  endtask

  task automatic t_flag();
    issue(12'o1405, 0, 0, 1, 0); chk("R8 skip flag clear", skip, 1);
    issue(12'o1401, 0, 0, 0, 1); chk("R8 skip flag set", skip, 1);
    issue(12'o1401, 0, 0, 1, 0); chk("R8 noskip flag clear", skip, 0);
    issue(12'o1410, 0, 0, 1, 1); chk("R8 clear flag", {ov_out, f_out}, 2'b10);
    issue(12'o1420, 0, 0, 0, 1); chk("R8 comp flag", {ov_out, f_out}, 2'b00);
    issue(12'o1430, 0, 0, 1, 0); chk("R8 set flag", {ov_out, f_out}, 2'b11);
  endtask

  task automatic t_misc();
    issue(12'o1442, 12'o5, 12'o6, 0, 0);
    chk("R9 always skip", skip, 1);
    issue(12'o1400, 12'o4321, 12'o1234, 1, 0);
    chk("R9 nop skip", skip, 0);
    chk("R9 nop values", {j_out, k_out, ov_out, f_out}, {12'o4321, 12'o1234, 2'b10});
  endtask

  task automatic t_timing();
    @(negedge clk);
    valid = 1'b1; instr = 12'o1442;
    @(posedge clk); #1;
    chk("R10 done at edge", {done, skip}, 2'b11);
    @(negedge clk);
    valid = 1'b0;
    @(negedge clk);
    chk("R10 skip one cycle", {done, skip}, 2'b00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_foreign();
    t_single();
    t_joint();
    t_modify();
    t_incneg();
    t_ovf();
    t_flag();
    t_misc();
    t_timing();
    finish_run();
  end
endmodule